// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data buses, A and B, each `W` bits wide. Each transfer direction owns a storage register with its own rising-edge clock, an output enable, and a source select. Within a direction, the select passes either the live value on the opposite bus or the value last captured in that direction's register. Each register samples its own source bus on every rising edge of its clock, whatever the enables and selects are set to. The block can therefore snapshot bus traffic while both sides stay isolated.

Each bus is split into an input vector, an output vector and a single drive flag, so the block synthesizes without internal tri-states. The surrounding fabric resolves these onto real bus wires. The two enables have opposite polarities: A-to-B drive is active high and B-to-A drive is active low. If both directions are enabled in live mode, each bus feeds the other. With no outside driver, that loop holds the last bus value. The source multiplexers are hazard-free, so changing a select while both of its sources agree leaves the output unchanged.

Top module: `regbus_xcvr`

## Requirements
- R1: `b_oe` equals `ab_en`: bus B is driven only while `ab_en` is 1.
- R2: `a_oe` is the inverse of `ba_en_n`: bus A is driven only while `ba_en_n` is 0. With `ab_en`=0 and `ba_en_n`=1, neither bus is driven.
- R3: With `ab_sel`=0, `b_out` equals `a_in`. With `ab_sel`=1, `b_out` equals the A-side register.
- R4: With `ba_sel`=0, `a_out` equals `b_in`. With `ba_sel`=1, `a_out` equals the B-side register.
- R5: The A-side register loads `a_in` on every rising edge of `a_clk`, and the B-side register loads `b_in` on every rising edge of `b_clk`. Capture ignores the enables and selects, and clocks applied at different times load independent values.
- R6: While `rst_n` is 0, both registers are zero at once (asynchronous), and clock edges do not load them.
- R7: When a register equals the live value of the same direction, toggling that direction's select leaves its output unchanged.
- R8: With both directions enabled and both selects at 0, once outside drivers release the buses, both buses keep their last value.
- R9: With one bus as input and the other driven live from it, clocking both registers loads the same input value into both.
- R10: With `ab_en`=1, `ba_en_n`=0 and both selects at 1, bus A carries the B-side register and bus B carries the A-side register at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| a_clk | input | 1 | Rising edge captures bus A into the A-side register |
| b_clk | input | 1 | Rising edge captures bus B into the B-side register |
| ab_en | input | 1 | Drive bus B (active high) |
| ba_en_n | input | 1 | Drive bus A (active low) |
| ab_sel | input | 1 | B source: 0 live bus A, 1 A-side register |
| ba_sel | input | 1 | A source: 0 live bus B, 1 B-side register |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | 1 | Bus A drive flag |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | 1 | Bus B drive flag |

## Verification
The bench steps through every operating mode in turn: isolation, capture from both sides, live and stored transfer in each direction, and dual stored transfer. It uses a distinct byte per step, so a swapped source, a swapped register or a wrong enable polarity each produce a distinct wrong bus value. Clocks applied together and clocks applied apart tell shared capture from independent capture. In the live-loop step the outside driver is released, which shows whether the buses hold their value. A select is toggled while register and live data agree, and reset is asserted with clock edges applied during it.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int unsigned BUS_W_DEF = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/regbus_hold_reg.sv
module regbus_hold_reg #(
  parameter int unsigned W = regbus_pkg::BUS_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         load;

  // capture is unconditional: enables and selects never gate it
  always_comb begin
    load  = 1'b1;
    q_nxt = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/regbus_hzmux.sv
module regbus_hzmux #(
  parameter int unsigned W = regbus_pkg::BUS_W_DEF
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  // consensus term keeps a bit steady across a select change when both inputs agree
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = (sel & stored[i]) | (~sel & live[i]) | (stored[i] & live[i]);
  end
endmodule

// File: rtl/regbus_lane.sv
module regbus_lane #(
  parameter int unsigned W      = regbus_pkg::BUS_W_DEF,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] src_bus,
  output logic [W-1:0] drv_data,
  output logic         drv_oe,
  output logic [W-1:0] held
);
  regbus_hold_reg #(.W(W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_bus),
    .q     (held)
  );

  regbus_hzmux #(.W(W)) u_mux (
    .sel    (sel),
    .live   (src_bus),
    .stored (held),
    .y      (drv_data)
  );

  if (OE_LOW) begin : g_oe_low
    assign drv_oe = ~en;
  end else begin : g_oe_high
    assign drv_oe = en;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int unsigned W = regbus_pkg::BUS_W_DEF
) (
  input  logic         rst_n,
  input  logic         a_clk,
  input  logic         b_clk,
  input  logic         ab_en,
  input  logic         ba_en_n,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] a_hold;
  logic [W-1:0] b_hold;

  // A side: captures bus A, drives bus B, active-high enable
  regbus_lane #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk      (a_clk),
    .rst_n    (rst_n),
    .en       (ab_en),
    .sel      (ab_sel),
    .src_bus  (a_in),
    .drv_data (b_out),
    .drv_oe   (b_oe),
    .held     (a_hold)
  );

  // B side: captures bus B, drives bus A, active-low enable
  regbus_lane #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk      (b_clk),
    .rst_n    (rst_n),
    .en       (ba_en_n),
    .sel      (ba_sel),
    .src_bus  (b_in),
    .drv_data (a_out),
    .drv_oe   (a_oe),
    .held     (b_hold)
  );
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned W = regbus_pkg::BUS_W_DEF
) (
  input logic         rst_n,
  input logic         a_clk,
  input logic         b_clk,
  input logic         ab_en,
  input logic         ba_en_n,
  input logic         ab_sel,
  input logic         ba_sel,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a_hold,
  input logic [W-1:0] b_hold
);
  AST_B_DRIVE_POL: assert property (@(posedge a_clk) disable iff (!rst_n)
    b_oe == ab_en); // R1
  AST_A_DRIVE_POL: assert property (@(posedge b_clk) disable iff (!rst_n)
    a_oe == !ba_en_n); // R2
  AST_A_SIDE_STORED: assert property (@(posedge a_clk) disable iff (!rst_n)
    1'b1 |=> (!ab_sel || b_out == $past(a_in))); // R3
  AST_B_SIDE_STORED: assert property (@(posedge b_clk) disable iff (!rst_n)
    1'b1 |=> (!ba_sel || a_out == $past(b_in))); // R4
  AST_A_CAPTURE: assert property (@(posedge a_clk) disable iff (!rst_n)
    1'b1 |=> (a_hold == $past(a_in))); // R5
  AST_A_CLEARED: assert property (@(posedge a_clk)
    !rst_n |-> (a_hold == '0)); // R6
  AST_B_CLEARED: assert property (@(posedge b_clk)
    !rst_n |-> (b_hold == '0)); // R6
  AST_NO_SEL_GLITCH: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_in == a_hold) |-> (b_out == a_in)); // R7
  AST_DUAL_STORED: assert property (@(posedge a_clk) disable iff (!rst_n)
    (ab_en && !ba_en_n && ab_sel && ba_sel) |->
      (a_oe && b_oe && b_out == a_hold && a_out == b_hold)); // R10
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
  localparam int W = 8;
  localparam int NV = 15;

  typedef struct packed {
    logic         ab_en, ba_en_n, ab_sel, ba_sel;
    logic         ea_en;
    logic [7:0]   ea;
    logic         eb_en;
    logic [7:0]   eb;
    logic         pa, pb;
    logic         xa_oe, xb_oe;
    logic [7:0]   xa, xb;
    logic [3:0]   req;
  } vec_t;

  // fields: ab_en ba_en_n ab_sel ba_sel | extA en,val | extB en,val | pulse a,b | exp a_oe b_oe busA busB | req
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h11, 1'b1,8'h22, 1'b0,1'b0, 1'b0,1'b0, 8'h11,8'h22, 4'd2},  // R2 isolation
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h11, 1'b1,8'h22, 1'b1,1'b1, 1'b0,1'b0, 8'h11,8'h22, 4'd5},  // R5 store both, disabled
    '{1'b1,1'b1,1'b1,1'b0, 1'b1,8'h33, 1'b0,8'h00, 1'b0,1'b0, 1'b0,1'b1, 8'h33,8'h11, 4'd3},  // R3 stored A->B
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'h33, 1'b0,8'h00, 1'b0,1'b0, 1'b0,1'b1, 8'h33,8'h33, 4'd3},  // R3 live A->B
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,8'h00, 1'b1,8'h44, 1'b0,1'b0, 1'b1,1'b0, 8'h22,8'h44, 4'd4},  // R4 stored B->A
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 1'b1,8'h44, 1'b0,1'b0, 1'b1,1'b0, 8'h44,8'h44, 4'd4},  // R4 live B->A
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 1'b1,8'h55, 1'b1,1'b1, 1'b1,1'b0, 8'h55,8'h55, 4'd9},  // R9 B into both
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1, 8'h55,8'h55, 4'd9},  // R9 readback
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h66, 1'b1,8'h77, 1'b1,1'b0, 1'b0,1'b0, 8'h66,8'h77, 4'd5},  // R5 A only
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'h66, 1'b1,8'h77, 1'b0,1'b1, 1'b0,1'b0, 8'h66,8'h77, 4'd5},  // R5 B only
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1, 8'h77,8'h66, 4'd10}, // R10 dual stored
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'h88, 1'b0,8'h00, 1'b1,1'b1, 1'b0,1'b1, 8'h88,8'h88, 4'd9},  // R9 A into both
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1, 8'h88,8'h88, 4'd10}, // R10 readback
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'h5a, 1'b0,8'h00, 1'b0,1'b0, 1'b0,1'b1, 8'h5a,8'h5a, 4'd8},  // R8 seed loop
    '{1'b1,1'b0,1'b0,1'b0, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1, 8'h5a,8'h5a, 4'd8}   // R8 released hold
  };

  logic clk = 1'b0;
  logic rst_n, a_clk, b_clk;
  logic ab_en, ba_en_n, ab_sel, ba_sel;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;
  logic ea_en, eb_en;
  logic [W-1:0] ea, eb;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  regbus_xcvr #(.W(W)) uut (
    .rst_n(rst_n), .a_clk(a_clk), .b_clk(b_clk),
    .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // bus resolution: outside driver, else block driver, else keeper holds last value
  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      #1;
      a_in = ea_en ? ea : (a_oe ? a_out : a_in);
      b_in = eb_en ? eb : (b_oe ? b_out : b_in);
    end
    #1;
  endtask

  task automatic pulse(input logic pa, input logic pb);
    a_clk = pa;
    b_clk = pb;
    #2;
    a_clk = 1'b0;
    b_clk = 1'b0;
    settle();
  endtask

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got oeA=%b oeB=%b A=%h B=%h exp oeA=%b oeB=%b A=%h B=%h",
               tag, got[17], got[16], got[15:8], got[7:0], exp[17], exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic set_ctl(input logic e_ab, input logic e_ba_n, input logic s_ab, input logic s_ba);
    ab_en = e_ab; ba_en_n = e_ba_n; ab_sel = s_ab; ba_sel = s_ba;
  endtask

  initial begin
    #(20000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_clk = 1'b0; b_clk = 1'b0;
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    ea_en = 1'b1; ea = 8'h00; eb_en = 1'b1; eb = 8'h00;
    a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: registers start at zero, seen through dual stored transfer
    ea_en = 1'b0; eb_en = 1'b0;
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    settle();
    check("R6 reset state", {a_oe, b_oe, a_in, b_in}, {1'b1, 1'b1, 8'h00, 8'h00});

    // R1: dropping ab_en releases bus B (keeper holds 00)
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    settle();
    check("R1 B released", {a_oe, b_oe, a_in, b_in}, {1'b1, 1'b0, 8'h00, 8'h00});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_ctl(VECS[i].ab_en, VECS[i].ba_en_n, VECS[i].ab_sel, VECS[i].ba_sel);
      ea_en = VECS[i].ea_en; ea = VECS[i].ea;
      eb_en = VECS[i].eb_en; eb = VECS[i].eb;
      settle();
      if (VECS[i].pa || VECS[i].pb) pulse(VECS[i].pa, VECS[i].pb);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), {a_oe, b_oe, a_in, b_in},
            {VECS[i].xa_oe, VECS[i].xb_oe, VECS[i].xa, VECS[i].xb});
    end

    // R7: register A holds 88; toggle ab_sel while bus A carries 88
    @(negedge clk);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    ea_en = 1'b1; ea = 8'h88; eb_en = 1'b0;
    settle();
    begin
      logic steady;
      steady = 1'b1;
      for (int t = 0; t < 8; t++) begin
        ab_sel = ~ab_sel;
        #1;
        if (b_out !== 8'h88) steady = 1'b0;
      end
      check("R7 select toggle", {1'b0, 1'b0, 7'd0, steady, b_out},
            {1'b0, 1'b0, 7'd0, 1'b1, 8'h88});
    end

    // R6: reset mid-run, clock edges during reset do not load
    @(negedge clk);
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    ea_en = 1'b1; ea = 8'hc3; eb_en = 1'b1; eb = 8'h3c;
    settle();
    rst_n = 1'b0;
    #1;
    pulse(1'b1, 1'b1);
    ea_en = 1'b0; eb_en = 1'b0;
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    settle();
    check("R6 in reset", {a_oe, b_oe, a_in, b_in}, {1'b1, 1'b1, 8'h00, 8'h00});
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R6 after release", {a_oe, b_oe, a_in, b_in}, {1'b1, 1'b1, 8'h00, 8'h00});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule